// File: doc/BRIEF.md
# Doorbell-Driven Interrupt Pending Controller

This block holds the pending state of the shared peripheral interrupts in an interrupt distributor and lets software, or a device that signals by a bus write, raise or drop that state by writing an interrupt number into one of four doorbell registers. Two doorbells serve the non-secure world and two serve the secure world. In each pair, one doorbell marks an interrupt pending and the other clears it. The interrupt number sits in the low ten bits of the written word.

Each doorbell write is qualified before it takes effect. The number must name an implemented shared interrupt. The pending bit must actually change. The security state of the access must be allowed to reach the interrupt, judged from the interrupt's group bit, its 2-bit non-secure access level and a global security-disable control. A write that fails any of these tests is dropped without any response. A successful write updates the pending bitmap at the next clock edge and produces a one-cycle change pulse that carries the interrupt number and the direction of the change.

A read-only type word tells software that doorbell signalling is available and how many interrupt lines exist. The group bits, the access levels and the security-disable bit are captured from configuration inputs on a load strobe. `NUM_LINES` must be a power of two and at least 64.

Top module: `doorbell_pend_ctrl`

## Requirements
- R1: While reset is held and after it is released, the pending vector is all zero and the change pulse is low. Reset also clears the group bits, the access levels and the security-disable bit.
- R2: When accepted, a write to the non-secure set doorbell (offset 0x040) or to the secure set doorbell (offset 0x050) makes the pending bit of the interrupt named by data bits 9:0 equal to 1 after the next rising edge. Data bits above bit 9 are ignored.
- R3: When accepted, a write to the non-secure clear doorbell (offset 0x048) or to the secure clear doorbell (offset 0x058) makes that pending bit 0 after the next rising edge.
- R4: A doorbell write whose number is below 32 or at least NUM_LINES has no effect.
- R5: A set write to an interrupt that is already pending has no effect. A clear write to an interrupt that is not pending has no effect.
- R6: An interrupt is secure when its group bit is 0 and security-disable is 0. On the non-secure set doorbell, a non-secure access (wr_ns=1) to a secure interrupt is dropped when that interrupt's access level is 0, and accepted when the level is 1, 2 or 3. A secure access is not restricted by the access level.
- R7: On the non-secure clear doorbell, a non-secure access to a secure interrupt is dropped when that interrupt's access level is 0 or 1, and accepted when the level is 2 or 3.
- R8: Both secure doorbells drop every write while security-disable is 1. They also drop every non-secure access.
- R9: While security-disable is 1, no interrupt is secure, so a non-secure access to the non-secure doorbells is never limited by the group bits or the access levels.
- R10: Every accepted write raises chg_o for exactly one cycle, in the same cycle the pending bit changes. During that cycle chg_id carries the interrupt number and chg_set carries the direction (1 = set, 0 = clear). No pulse appears for a dropped write.
- R11: A read at offset 0x004 returns a word with bit 17 = 1, bit 16 = 1 and bits 4:0 = ceil(NUM_LINES/32) - 1, and all other bits 0. Reads of any other offset, including the four doorbells, return 0. Writes to unmapped offsets have no effect.
- R12: On a rising edge with cfg_load = 1, the group bits, the access levels and the security-disable bit take the values on the cfg inputs. A doorbell write in that same cycle is judged against the configuration held before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data; bits 9:0 carry the interrupt number |
| wr_ns | input | 1 | 1 = non-secure access, 0 = secure access |
| rd_addr | input | ADDR_W | Byte offset of the combinational read |
| rd_data | output | 32 | Read data |
| cfg_load | input | 1 | Load strobe for the configuration below |
| cfg_sec_off | input | 1 | Security-disable value |
| cfg_grp | input | NUM_LINES | Group bit per interrupt (0 = secure group) |
| cfg_acc | input | 2*NUM_LINES | Non-secure access level per interrupt; interrupt n uses bits 2n+1:2n |
| pend_o | output | NUM_LINES | Pending bitmap |
| chg_o | output | 1 | One-cycle pulse on an accepted doorbell write |
| chg_id | output | 10 | Interrupt number of the last change |
| chg_set | output | 1 | Direction of the last change, 1 = set |

## Verification
A configuration load and a doorbell write can fall in the same cycle. The write must then be judged against the configuration held before the load. The bench provokes this by driving cfg_load together with a non-secure doorbell write whose outcome flips between the old and new group and access settings. It then checks that the old outcome appears at the next edge, and that repeating the write one cycle later gives the new outcome. Around this, the bench sweeps every doorbell against both access states, both security-disable values, both group values, all four access levels and both prior pending states, and computes each expected outcome from the rules.

// File: rtl/dbl_pkg.sv
package dbl_pkg;

    localparam logic [11:0] OFF_TYPE   = 12'h004;
    localparam logic [11:0] OFF_SET_NS = 12'h040;
    localparam logic [11:0] OFF_CLR_NS = 12'h048;
    localparam logic [11:0] OFF_SET_S  = 12'h050;
    localparam logic [11:0] OFF_CLR_S  = 12'h058;

    localparam int ID_W         = 10;
    localparam int FIRST_SHARED = 32;

    typedef enum logic [1:0] {
        DB_NONE = 2'd0,
        DB_SET  = 2'd1,
        DB_CLR  = 2'd2
    } db_op_e;

    // Capability word: doorbell support, bit 17 flag, line count field
    function automatic logic [31:0] type_word(input int lines);
        logic [31:0] w;
        w        = '0;
        w[17]    = 1'b1;
        w[16]    = 1'b1;
        w[4:0]   = 5'(((lines + 31) / 32) - 1);
        return w;
    endfunction

endpackage

// File: rtl/dbl_decode.sv
module dbl_decode
    import dbl_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LINES = 64
) (
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [31:0]         wr_data,
    output db_op_e              op,
    output logic                sec_reg,
    output logic [ID_W-1:0]     id,
    output logic                id_ok
);

    always_comb begin
        op      = DB_NONE;
        sec_reg = 1'b0;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(OFF_SET_NS)) begin
                op = DB_SET;
            end else if (wr_addr == ADDR_W'(OFF_CLR_NS)) begin
                op = DB_CLR;
            end else if (wr_addr == ADDR_W'(OFF_SET_S)) begin
                op      = DB_SET;
                sec_reg = 1'b1;
            end else if (wr_addr == ADDR_W'(OFF_CLR_S)) begin
                op      = DB_CLR;
                sec_reg = 1'b1;
            end
        end
    end

    assign id    = wr_data[ID_W-1:0];
    assign id_ok = (32'(id) >= FIRST_SHARED) && (32'(id) < NUM_LINES);

endmodule

// File: rtl/dbl_permit.sv
module dbl_permit
    import dbl_pkg::*;
(
    input  db_op_e      op,
    input  logic        sec_reg,
    input  logic        wr_ns,
    input  logic        sec_off,
    input  logic        grp_bit,
    input  logic [1:0]  acc,
    input  logic        pend_bit,
    input  logic        id_ok,
    output logic        go
);

    logic is_set;
    logic changes;
    logic ns_hits_secure;
    logic level_ok;
    logic world_ok;

    assign is_set         = (op == DB_SET);
    assign changes        = is_set ? !pend_bit : pend_bit;
    assign ns_hits_secure = wr_ns && !grp_bit && !sec_off;
    assign level_ok       = is_set ? (acc != 2'd0) : (acc >= 2'd2);

    always_comb begin
        if (sec_reg) begin
            world_ok = !sec_off && !wr_ns;
        end else begin
            world_ok = !ns_hits_secure || level_ok;
        end
    end

    assign go = (op != DB_NONE) && id_ok && changes && world_ok;

endmodule

// File: rtl/doorbell_pend_ctrl.sv
module doorbell_pend_ctrl
    import dbl_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LINES = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [31:0]            wr_data,
    input  logic                   wr_ns,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [31:0]            rd_data,
    input  logic                   cfg_load,
    input  logic                   cfg_sec_off,
    input  logic [NUM_LINES-1:0]   cfg_grp,
    input  logic [2*NUM_LINES-1:0] cfg_acc,
    output logic [NUM_LINES-1:0]   pend_o,
    output logic                   chg_o,
    output logic [9:0]             chg_id,
    output logic                   chg_set
);

    localparam int IDX_W = $clog2(NUM_LINES);
    localparam logic [31:0] TYPE_VAL = type_word(NUM_LINES);

    typedef struct packed {
        logic [NUM_LINES-1:0]   pend;
        logic [NUM_LINES-1:0]   grp;
        logic [2*NUM_LINES-1:0] acc;
        logic                   sec_off;
        logic                   chg;
        logic [ID_W-1:0]        chg_id;
        logic                   chg_set;
    } st_t;

    st_t st_d, st_q;

    db_op_e           dec_op;
    logic             dec_sec;
    logic [ID_W-1:0]  dec_id;
    logic             dec_ok;
    logic [IDX_W-1:0] idx;
    logic             go;

    dbl_decode #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .op      (dec_op),
        .sec_reg (dec_sec),
        .id      (dec_id),
        .id_ok   (dec_ok)
    );

    assign idx = dec_id[IDX_W-1:0];

    dbl_permit u_perm (
        .op       (dec_op),
        .sec_reg  (dec_sec),
        .wr_ns    (wr_ns),
        .sec_off  (st_q.sec_off),
        .grp_bit  (st_q.grp[idx]),
        .acc      (st_q.acc[{idx, 1'b0} +: 2]),
        .pend_bit (st_q.pend[idx]),
        .id_ok    (dec_ok),
        .go       (go)
    );

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (cfg_load) begin
            st_d.grp     = cfg_grp;
            st_d.acc     = cfg_acc;
            st_d.sec_off = cfg_sec_off;
        end
        if (go) begin
            st_d.pend[idx] = (dec_op == DB_SET);
            st_d.chg       = 1'b1;
            st_d.chg_id    = dec_id;
            st_d.chg_set   = (dec_op == DB_SET);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = (rd_addr == ADDR_W'(OFF_TYPE)) ? TYPE_VAL : 32'd0;
    assign pend_o  = st_q.pend;
    assign chg_o   = st_q.chg;
    assign chg_id  = st_q.chg_id;
    assign chg_set = st_q.chg_set;

endmodule

// File: rtl/dbl_chk.sv
module dbl_chk
    import dbl_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LINES = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic                 wr_ns,
    input logic [ADDR_W-1:0]    rd_addr,
    input logic [31:0]          rd_data,
    input logic [NUM_LINES-1:0] pend_o,
    input logic                 chg_o,
    input logic [9:0]           chg_id,
    input logic                 chg_set
);

    localparam int IDX_W = $clog2(NUM_LINES);

    // R10
    pend_moves_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o != $past(pend_o)) |-> chg_o);

    // R10
    single_bit_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |-> ($countones(pend_o ^ $past(pend_o)) == 1));

    // R2
    pulse_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |-> (pend_o[chg_id[IDX_W-1:0]] == chg_set));

    // R4
    pulse_id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |-> ((32'(chg_id) >= FIRST_SHARED) && (32'(chg_id) < NUM_LINES)));

    // R8
    secure_door_ns_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ns && ((wr_addr == ADDR_W'(OFF_SET_S)) || (wr_addr == ADDR_W'(OFF_CLR_S))))
        |=> !chg_o);

    // R11
    type_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(OFF_TYPE)) |-> (rd_data[17:16] == 2'b11));

endmodule

bind doorbell_pend_ctrl dbl_chk #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_ns   (wr_ns),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .pend_o  (pend_o),
    .chg_o   (chg_o),
    .chg_id  (chg_id),
    .chg_set (chg_set)
);

// File: tb/sim_doorbell_pend_ctrl.sv
`timescale 1ns/1ps
module sim_doorbell_pend_ctrl;

    localparam int AW = 12;
    localparam int NL = 64;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [31:0]     wr_data;
    logic            wr_ns;
    logic [AW-1:0]   rd_addr;
    logic [31:0]     rd_data;
    logic            cfg_load;
    logic            cfg_sec_off;
    logic [NL-1:0]   cfg_grp;
    logic [2*NL-1:0] cfg_acc;
    logic [NL-1:0]   pend_o;
    logic            chg_o;
    logic [9:0]      chg_id;
    logic            chg_set;

    int checks = 0;
    int errors = 0;

    // bench model of the state
    logic [NL-1:0]   m_pend;
    logic [NL-1:0]   m_grp;
    logic [2*NL-1:0] m_acc;
    logic            m_soff;

    doorbell_pend_ctrl #(.ADDR_W(AW), .NUM_LINES(NL)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ns(wr_ns), .rd_addr(rd_addr), .rd_data(rd_data),
        .cfg_load(cfg_load), .cfg_sec_off(cfg_sec_off), .cfg_grp(cfg_grp),
        .cfg_acc(cfg_acc), .pend_o(pend_o), .chg_o(chg_o), .chg_id(chg_id),
        .chg_set(chg_set)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int door_of(input logic [AW-1:0] a);
        case (a)
            12'h040: return 0;
            12'h048: return 1;
            12'h050: return 2;
            12'h058: return 3;
            default: return -1;
        endcase
    endfunction

    // expected acceptance from the requirements
    function automatic bit accepts(input int door, input bit ns, input int id,
                                   output string tag);
        bit set_op, secure_int;
        int lvl;
        if (door < 0) begin tag = "R11"; return 0; end
        set_op = (door == 0) || (door == 2);
        if (id < 32 || id >= NL) begin tag = "R4"; return 0; end
        if (set_op == m_pend[id]) begin tag = "R5"; return 0; end
        if (door >= 2) begin
            tag = "R8";
            if (m_soff || ns) return 0;
            tag = set_op ? "R2" : "R3";
            return 1;
        end
        secure_int = !m_grp[id] && !m_soff;
        lvl = int'(m_acc[2*id +: 2]);
        if (m_soff) tag = "R9";
        else tag = set_op ? "R2" : "R3";
        if (ns && secure_int) begin
            tag = set_op ? "R6" : "R7";
            if (set_op && lvl == 0) return 0;
            if (!set_op && lvl < 2) return 0;
        end
        return 1;
    endfunction

    // drive at negedge, check at the following negedge; optional config load same cycle
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input bit ns,
                      input bit ld = 0, input bit soff = 0,
                      input logic [NL-1:0] g = '0, input logic [2*NL-1:0] ac = '0);
        string tag;
        bit go;
        int id;
        id = int'(d[9:0]);
        go = accepts(door_of(a), ns, id, tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_ns = ns;
        cfg_load = ld; cfg_sec_off = soff; cfg_grp = g; cfg_acc = ac;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; cfg_load = 1'b0;
        if (ld) begin m_grp = g; m_acc = ac; m_soff = soff; end
        if (go) m_pend[id] = (door_of(a) == 0 || door_of(a) == 2);
        chk(chg_o == go, tag, "chg_o", 128'(chg_o), 128'(go));
        if (go) begin
            chk(chg_id == d[9:0] && chg_set == m_pend[id], "R10", "chg_id/chg_set",
                128'({chg_id, chg_set}), 128'({d[9:0], m_pend[id]}));
        end
        chk(pend_o == m_pend, tag, "pend_o", 128'(pend_o), 128'(m_pend));
    endtask

    task automatic load(input bit soff, input logic [NL-1:0] g, input logic [2*NL-1:0] ac);
        cfg_load = 1'b1; cfg_sec_off = soff; cfg_grp = g; cfg_acc = ac;
        @(posedge clk);
        @(negedge clk);
        cfg_load = 1'b0;
        m_grp = g; m_acc = ac; m_soff = soff;
    endtask

    function automatic logic [2*NL-1:0] rep_acc(input logic [1:0] v);
        logic [2*NL-1:0] r;
        for (int i = 0; i < NL; i++) r[2*i +: 2] = v;
        return r;
    endfunction

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] tw;
        rst_n = 1'b0; wr_en = 0; wr_addr = '0; wr_data = '0; wr_ns = 0;
        rd_addr = '0; cfg_load = 0; cfg_sec_off = 0; cfg_grp = '0; cfg_acc = '0;
        m_pend = '0; m_grp = '0; m_acc = '0; m_soff = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pend_o == '0 && chg_o == 1'b0, "R1", "reset state", 128'({pend_o, chg_o}), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pend_o == '0 && chg_o == 1'b0, "R1", "after reset", 128'({pend_o, chg_o}), 128'd0);

        // R11: type word and read-as-zero offsets
        rd_addr = 12'h004; #1;
        tw = (32'd1 << 17) | (32'd1 << 16) | 32'(((NL + 31) / 32) - 1);
        chk(rd_data == tw, "R11", "type word", 128'(rd_data), 128'(tw));
        for (int k = 0; k < 4; k++) begin
            rd_addr = AW'(12'h040 + 8 * k); #1;
            chk(rd_data == 32'd0, "R11", "doorbell read", 128'(rd_data), 128'd0);
        end

        // R2/R4/R9 id boundaries with security disabled
        load(1'b1, '0, '0);
        wr(12'h040, 32'd31, 1'b1);
        wr(12'h040, 32'd32, 1'b1);
        wr(12'h040, 32'd63, 1'b1);
        wr(12'h040, 32'd64, 1'b1);
        wr(12'h040, 32'd1023, 1'b1);
        wr(12'h040, 32'hFFFF_FC28, 1'b1);      // R2: upper bits ignored, id 40
        @(negedge clk);
        chk(chg_o == 1'b0, "R10", "pulse one cycle", 128'(chg_o), 128'd0);
        wr(12'h044, 32'd50, 1'b0);              // R11 unmapped write
        wr(12'h050, 32'd50, 1'b0);              // R8 secure door while disabled
        wr(12'h048, 32'd32, 1'b1);              // R3
        wr(12'h048, 32'd32, 1'b1);              // R5 clear when not pending
        wr(12'h040, 32'd63, 1'b1);              // R5 set when pending

        // Near-exhaustive sweep: door x ns x soff x grp x acc x prior pending
        for (int door = 0; door < 4; door++)
          for (int ns = 0; ns < 2; ns++)
            for (int so = 0; so < 2; so++)
              for (int g = 0; g < 2; g++)
                for (int a = 0; a < 4; a++)
                  for (int p = 0; p < 2; p++) begin
                      int id;
                      id = 32 + ((door * 7 + ns * 5 + so * 3 + g * 11 + a * 2 + p) % 32);
                      load(1'b0, '0, '0);
                      if (m_pend[id] != p[0])
                          wr(p[0] ? 12'h050 : 12'h058, 32'(id), 1'b0);
                      load(so[0], {NL{g[0]}}, rep_acc(a[1:0]));
                      wr(AW'(12'h040 + 8 * door), 32'(id), ns[0]);
                  end

        // R12: config load in same cycle as a doorbell write
        load(1'b0, '0, '0);
        if (m_pend[45]) wr(12'h058, 32'd45, 1'b0);
        wr(12'h040, 32'd45, 1'b1, 1'b1, 1'b0, {NL{1'b1}}, '0);   // old config: dropped
        chk(pend_o[45] == 1'b0, "R12", "judged by old config", 128'(pend_o[45]), 128'd0);
        wr(12'h040, 32'd45, 1'b1);                                // new config: accepted
        chk(pend_o[45] == 1'b1, "R12", "new config applies", 128'(pend_o[45]), 128'd1);
        wr(12'h048, 32'd45, 1'b1, 1'b1, 1'b0, '0, rep_acc(2'd1)); // old: group 1 -> accepted
        chk(pend_o[45] == 1'b0, "R12", "clear under old config", 128'(pend_o[45]), 128'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule